// File: doc/BRIEF.md
# Latched Interrupt Controller With Register Access

This block gathers up to 32 interrupt lines for a small processor core and presents them as two special-purpose registers: an enable register and a pending register. Each line is first passed through a two-flop synchroniser. A parameter marks each line as edge-sensitive or level-sensitive. Either way, the event is captured in a pending bit that stays set until software clears it. The block drives one registered interrupt request to the core whenever some pending bit is also enabled.

Software reads and writes the two registers through a single-cycle port. A 1-bit select chooses between them. A parameter sets how status writes clear bits. In the default mode, each 1 in the written word clears the matching pending bit. In the inverted mode, each 0 clears its bit, so a read-modify-write that drops one bit leaves the others pending. If a line event and a clear of the same bit land in the same cycle, the event wins.

A second registered output gives the number of the lowest-numbered pending, enabled line, with a valid flag. A handler can use it instead of scanning the pending word.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, the enable register reads 0, the pending register reads 0, and `irq_req` and `first_vld` are 0.
- R2: An enable bit of 1 lets its pending line raise `irq_req`. An enable bit of 0 keeps the line from raising it, but the line still shows as pending.
- R3: On an edge-sensitive line, a rising input sets the pending bit. The bit stays set after the input falls, and it is cleared only by a status write.
- R4: On a level-sensitive line, a high input sets the pending bit. The bit stays set after the input falls, and while the input is still high a clear has no lasting effect.
- R5: With `CLR_ON_ONE`=1, a status write clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R6: With `CLR_ON_ONE`=0, a status write clears every pending bit written as 0 and leaves every bit written as 1 unchanged.
- R7: If a line sets its pending bit in the same cycle as a clear of that bit, the bit ends up set.
- R8: `acc_sel`=0 addresses the enable register and `acc_sel`=1 addresses the pending register. A write to the enable register loads the whole word. A read returns the addressed register on `acc_rdata` one cycle later.
- R9: `irq_req` is registered. It is 1 exactly one cycle after the AND of pending and enable is non-zero.
- R10: `first_vld` is 1 when some line is both pending and enabled, and `first_idx` then gives the lowest such line number. Both outputs are registered together with `irq_req`.
- R11: An input change reaches the pending bit on the third clock edge and reaches `irq_req` on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_LINES | Asynchronous interrupt inputs |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_sel | input | 1 | 0 selects enable, 1 selects pending |
| acc_wdata | input | NUM_LINES | Write data |
| acc_rdata | output | NUM_LINES | Registered read data |
| irq_req | output | 1 | Registered request to the processor |
| first_idx | output | IDX_W | Lowest pending enabled line |
| first_vld | output | 1 | `first_idx` is meaningful |

## Verification
A pending bit that falls without a clear shows up as `irq_req` dropping within one cycle while its line is enabled. It is also visible on the next status read. An enable bit or a clear polarity stored wrong shows up the same way, one cycle after the write, on `irq_req` and on `first_idx`. A synchroniser of the wrong depth shifts the request edge off its expected fourth-edge slot, so the latency check reports it directly. The set-versus-clear race is driven on the exact edge where the pending bit is set, and the result is read back at the status port.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    SEL_ENABLE  = 1'b0,
    SEL_PENDING = 1'b1
  } acc_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int NUM_LINES = 32,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] din,
  output logic [NUM_LINES-1:0] dout
);
  logic [NUM_LINES-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int                   NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] EDGE_MAP  = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] sync_in,
  input  logic [NUM_LINES-1:0] clr_vec,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] set_vec
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_in;
  end

  // Edge lines fire on 0->1, level lines fire while high.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (EDGE_MAP[i]) begin : g_edge
      assign set_vec[i] = sync_in[i] & ~prev_q[i];
    end else begin : g_level
      assign set_vec[i] = sync_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_vec) | set_vec;
  end

  // R7: a set in the same cycle as a clear leaves the bit set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  // R3: without a clear no pending bit falls
  a_r3_hold_no_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_vec == '0) |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

// File: rtl/irq_first.sv
module irq_first #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] vec,
  output logic [IDX_W-1:0]     idx_q,
  output logic                 vld_q
);
  logic [IDX_W-1:0] idx_c;

  always_comb begin
    idx_c = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (vec[i]) idx_c = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_c;
      vld_q <= |vec;
    end
  end

  // R10: valid flag tracks a non-empty vector one cycle earlier
  a_r10_vld_track: assert property (@(posedge clk) disable iff (rst)
    ##1 (vld_q == $past(vec != '0)));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int                   NUM_LINES   = 32,
  parameter int                   SYNC_STAGES = 2,
  parameter bit                   CLR_ON_ONE  = 1'b1,
  parameter logic [NUM_LINES-1:0] EDGE_MAP    = 32'h0000_FFFF,
  parameter int                   IDX_W       = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_in,
  input  logic                 acc_wr,
  input  logic                 acc_rd,
  input  logic                 acc_sel,
  input  logic [NUM_LINES-1:0] acc_wdata,
  output logic [NUM_LINES-1:0] acc_rdata,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     first_idx,
  output logic                 first_vld
);
  logic [NUM_LINES-1:0] sync_w;
  logic [NUM_LINES-1:0] pend_w;
  logic [NUM_LINES-1:0] set_w;
  logic [NUM_LINES-1:0] clr_w;
  logic [NUM_LINES-1:0] enable_q;
  logic [NUM_LINES-1:0] live_w;
  logic                 pend_wr;

  irq_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(line_in), .dout(sync_w)
  );

  assign pend_wr = acc_wr && (acc_sel == SEL_PENDING);

  if (CLR_ON_ONE) begin : g_clr_one
    assign clr_w = pend_wr ? acc_wdata : '0;
  end else begin : g_clr_zero
    assign clr_w = pend_wr ? ~acc_wdata : '0;
  end

  irq_pend #(.NUM_LINES(NUM_LINES), .EDGE_MAP(EDGE_MAP)) pend_i (
    .clk(clk), .rst(rst), .sync_in(sync_w), .clr_vec(clr_w),
    .pend_q(pend_w), .set_vec(set_w)
  );

  always_ff @(posedge clk) begin
    if (rst)                                    enable_q <= '0;
    else if (acc_wr && acc_sel == SEL_ENABLE)   enable_q <= acc_wdata;
  end

  assign live_w = pend_w & enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      acc_rdata <= '0;
    end else begin
      irq_req <= |live_w;
      if (acc_rd) acc_rdata <= (acc_sel == SEL_PENDING) ? pend_w : enable_q;
    end
  end

  irq_first #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) first_i (
    .clk(clk), .rst(rst), .vec(live_w), .idx_q(first_idx), .vld_q(first_vld)
  );

  // R1: enable register is empty right after reset
  a_r1_enable_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enable_q == '0));

  // R2: nothing enabled and pending means no request next cycle
  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (live_w == '0) |=> !irq_req);

  // R10: request and valid flag agree
  a_r10_req_vld: assert property (@(posedge clk) disable iff (rst)
    irq_req == first_vld);

  // R6: in inverted mode an all-ones write never drops a bit
  a_r6_ones_keep: assert property (@(posedge clk) disable iff (rst)
    (!CLR_ON_ONE && pend_wr && acc_wdata == '1) |=>
      (($past(pend_w) & ~pend_w) == '0));
endmodule

// File: tb/irq_latch_ctrl_tb_top.sv
module irq_latch_ctrl_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] line_in = '0;
  logic        wr_a = 0, rd_a = 0, wr_b = 0, rd_b = 0, sel = 0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata_a, rdata_b;
  logic        req_a, req_b, vld_a, vld_b;
  logic [4:0]  idx_a, idx_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  irq_latch_ctrl #(.CLR_ON_ONE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .line_in(line_in), .acc_wr(wr_a), .acc_rd(rd_a),
    .acc_sel(sel), .acc_wdata(wdata), .acc_rdata(rdata_a), .irq_req(req_a),
    .first_idx(idx_a), .first_vld(vld_a)
  );

  irq_latch_ctrl #(.CLR_ON_ONE(1'b0)) dut_w0_i (
    .clk(clk), .rst(rst), .line_in(line_in), .acc_wr(wr_b), .acc_rd(rd_b),
    .acc_sel(sel), .acc_wdata(wdata), .acc_rdata(rdata_b), .irq_req(req_b),
    .first_idx(idx_b), .first_vld(vld_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input bit b, input bit s, input logic [31:0] d);
    sel = s; wdata = d;
    if (b) wr_b = 1; else wr_a = 1;
    cyc(1);
    wr_a = 0; wr_b = 0;
  endtask

  task automatic rd_reg(input bit b, input bit s, output logic [31:0] d);
    sel = s;
    if (b) rd_b = 1; else rd_a = 1;
    cyc(1);
    rd_a = 0; rd_b = 0;
    d = b ? rdata_b : rdata_a;
  endtask

  task automatic pulse(input logic [31:0] lines);
    line_in = line_in | lines;
    cyc(1);
    line_in = line_in & ~lines;
    cyc(4);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_req", req_a, 0);
    check("R1 first_vld", vld_a, 0);
    rd_reg(0, 0, d); check("R1 enable", d, 0);
    rd_reg(0, 1, d); check("R1 pending", d, 0);
  endtask

  task automatic t_enable_rw();
    logic [31:0] d;
    wr_reg(0, 0, 32'hA5A5_0F0F);
    rd_reg(0, 0, d); check("R8 enable readback", d, 32'hA5A5_0F0F);
    wr_reg(0, 0, 32'h0);
    rd_reg(0, 0, d); check("R8 enable cleared", d, 0);
  endtask

  task automatic t_mask_block();
    logic [31:0] d;
    pulse(32'h8);
    check("R2 masked no req", req_a, 0);
    rd_reg(0, 1, d); check("R2 masked still pending", d, 32'h8);
    wr_reg(0, 0, 32'h8);
    check("R9 req not yet", req_a, 0);
    cyc(1);
    check("R9 req one cycle after enable", req_a, 1);
    check("R10 idx 3", {vld_a, 26'd0, idx_a}, {1'b1, 26'd0, 5'd3});
  endtask

  task automatic t_edge_w1c();
    logic [31:0] d;
    cyc(10);
    rd_reg(0, 1, d); check("R3 edge bit held", d, 32'h8);
    wr_reg(0, 1, 32'hFFFF_FFF7);
    rd_reg(0, 1, d); check("R5 zero bit kept", d, 32'h8);
    wr_reg(0, 1, 32'h8);
    rd_reg(0, 1, d); check("R5 one bit cleared", d, 0);
    check("R9 req dropped", req_a, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr_reg(0, 0, 32'h0010_0000);
    line_in[20] = 1'b1;
    cyc(5);
    wr_reg(0, 1, 32'h0010_0000);
    rd_reg(0, 1, d); check("R4 clear while high ignored", d, 32'h0010_0000);
    line_in[20] = 1'b0;
    cyc(6);
    rd_reg(0, 1, d); check("R4 level latched after drop", d, 32'h0010_0000);
    check("R4 req still high", req_a, 1);
    wr_reg(0, 1, 32'h0010_0000);
    rd_reg(0, 1, d); check("R4 level cleared", d, 0);
  endtask

  task automatic t_latency();
    wr_reg(0, 0, 32'h80);
    line_in[7] = 1'b1;
    cyc(1); check("R11 edge1", req_a, 0);
    cyc(1); check("R11 edge2", req_a, 0);
    cyc(1); check("R11 edge3", req_a, 0);
    cyc(1); check("R11 edge4", req_a, 1);
    line_in[7] = 1'b0;
    wr_reg(0, 1, 32'h80);
    cyc(2);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    line_in[8] = 1'b1;
    cyc(2);
    sel = 1; wdata = 32'h100; wr_a = 1;
    cyc(1);
    wr_a = 0; line_in[8] = 1'b0;
    rd_reg(0, 1, d); check("R7 set beats clear", d, 32'h100);
    wr_reg(0, 1, 32'h100);
    rd_reg(0, 1, d); check("R7 later clear works", d, 0);
  endtask

  task automatic t_lowest();
    pulse(32'h0000_0220);
    wr_reg(0, 0, 32'hFFFF_FFFF);
    cyc(1);
    check("R10 lowest is 5", {vld_a, 26'd0, idx_a}, {1'b1, 26'd0, 5'd5});
    wr_reg(0, 0, 32'hFFFF_FFDF);
    cyc(1);
    check("R10 lowest is 9", {vld_a, 26'd0, idx_a}, {1'b1, 26'd0, 5'd9});
    wr_reg(0, 1, 32'hFFFF_FFFF);
    cyc(1);
    check("R10 none valid", vld_a, 0);
  endtask

  task automatic t_w0c();
    logic [31:0] d;
    wr_reg(1, 1, 32'h0);
    rd_reg(1, 1, d); check("R6 zeros clear all", d, 0);
    pulse(32'h14);
    rd_reg(1, 1, d); check("R6 two pending", d, 32'h14);
    wr_reg(1, 1, ~32'h4);
    rd_reg(1, 1, d); check("R6 zero bit cleared", d, 32'h10);
    wr_reg(1, 1, 32'hFFFF_FFFF);
    rd_reg(1, 1, d); check("R6 ones keep", d, 32'h10);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_enable_rw();
    t_mask_block();
    t_edge_w1c();
    t_level();
    t_latency();
    t_set_wins();
    t_lowest();
    t_w0c();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule